// File: doc/BRIEF.md
# SCSI Host Controller Command Register Engine

This block is the byte-wide register front end of a simple SCSI host controller. The host reaches it through a small bus. A write always stores into a bank of host-programmed registers. A read always returns a separate bank of result registers, which hold the status, the interrupt reason, the sequence step and a revision identifier. Both banks are selected by the same register index, and that index comes from the low address bits. Registers are one byte wide and placed four bytes apart.

Writing the command register dispatches an operation. Flush and chip reset complete at once. The three transfer-type commands start a handshake with an external transfer stub, which stands in for the memory DMA engine. When the stub reports done, the block loads a fixed completion encoding into the status, interrupt-reason and sequence-step registers. It also sets a flag bit in DMA control register 0 and raises the interrupt line. The host clears that line with a write to DMA control register 0 that has its enable bit low. A command written while a transfer is pending is dropped.

Top module: `scsi_cmd_regfile`

## Requirements
- R1: The register index is bus address bits [5:2]. Address bits above bit 5 are ignored, so address 0x4C reaches the command register (index 3) and 0x54 reads index 5.
- R2: After reset every read register is 0 except index 14, which holds 0x04. The interrupt line, busy and all four DMA control registers are 0.
- R3: A bus write never changes what a read of the same index returns. Writing 0xAA to index 5 leaves the read of index 5 at its previous value.
- R4: Only the low 7 bits of a command byte choose the operation. 0x90 behaves as 0x10, and 0x81 behaves as 0x01.
- R5: Opcode 0x01 (flush) sets the interrupt register (read index 5) to 0x08 and the sequence step (read index 6) to 0. The status register (index 4) and the interrupt line stay unchanged.
- R6: Opcode 0x02 (chip reset) clears every read register, loads index 14 with 0x04 and clears all four DMA control registers. All of this takes effect on the clock edge that takes the write.
- R7: Opcode 0x10 raises busy and xfer_req, with xfer_len equal to write register 0 plus 256 times write register 1. On done, status becomes 0x93, interrupt 0x10 and step 0.
- R8: Opcode 0x11 requests a 2-byte transfer. On done, status becomes 0x93, interrupt 0x18 and step 4.
- R9: Opcode 0x12 requests a 2-byte transfer. On done, status becomes 0x93, interrupt 0x20 and step 0.
- R10: On the edge where done is seen with busy high, bit 0 of DMA register 0 is set, irq goes high and busy falls.
- R11: A write to DMA register 0 (dma_addr bits [3:2] = 0) with data bit 4 clear drops irq. The same write with bit 4 set leaves irq high.
- R12: Opcodes other than 0x01, 0x02, 0x10, 0x11 and 0x12 leave the read registers and irq unchanged. This includes 0x00, 0x03 and 0x1A.
- R13: A command written while busy is ignored. Busy, xfer_len and the read registers keep their values until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read bank value at the current index |
| dma_wr | input | 1 | DMA control register write strobe |
| dma_addr | input | 4 | DMA register byte address, bits [3:2] select |
| dma_wdata | input | DMA_W | DMA register write data |
| dma_rdata | output | DMA_W | DMA register value at dma_addr |
| xfer_req | output | 1 | Transfer requested from the stub |
| xfer_len | output | 16 | Bytes to move for the pending transfer |
| xfer_done | input | 1 | Stub reports the transfer finished |
| busy | output | 1 | A transfer command is pending |
| irq | output | 1 | Interrupt line |

## Verification
The main dispatch is tried with every transfer opcode, with the top opcode bit set and clear, and with length bytes of zero, all ones and mixed values. This separates a length built from the wrong bytes or in the wrong order, and it exposes decoding that uses all 8 bits of the opcode. Flush, no-op and unknown opcodes are applied on top of a non-zero completion state, so that a register wrongly cleared or rewritten shows up. Commands written during a pending transfer, and DMA writes with the enable bit high and low, tell apart a correct busy guard and interrupt clear from their mutants.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  localparam int IDX_W   = 4;
  localparam int N_REGS  = 1 << IDX_W;

  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_CMD    = 3;
  localparam int IDX_STAT   = 4;
  localparam int IDX_INTR   = 5;
  localparam int IDX_SEQ    = 6;
  localparam int IDX_REV    = 14;

  localparam logic [7:0] REV_ID     = 8'h04;
  localparam logic [2:0] PH_STATUS  = 3'd3;
  localparam logic [7:0] ST_TC      = 8'h10;
  localparam logic [7:0] ST_PEND    = 8'h80;
  localparam logic [7:0] IR_FDONE   = 8'h08;
  localparam logic [7:0] IR_BSERV   = 8'h10;
  localparam logic [7:0] IR_DISC    = 8'h20;
  localparam logic [7:0] SEQ_CMDOK  = 8'h04;
  localparam logic [15:0] MSG_BYTES = 16'd2;

  typedef enum logic [2:0] {
    K_NONE, K_FLUSH, K_CHIPRST, K_XINFO, K_XCMPL, K_XMSGOK, K_UNKNOWN
  } cmd_kind_e;

  typedef struct packed {
    logic [7:0] status;
    logic [7:0] intr;
    logic [7:0] seq;
  } cmpl_code_t;

  function automatic logic [IDX_W-1:0] reg_index(input logic [5:0] a);
    return a[5:2];
  endfunction

  function automatic logic [15:0] count16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  function automatic cmd_kind_e classify(input logic [6:0] op);
    case (op)
      7'h00, 7'h03, 7'h1A: return K_NONE;
      7'h01:               return K_FLUSH;
      7'h02:               return K_CHIPRST;
      7'h10:               return K_XINFO;
      7'h11:               return K_XCMPL;
      7'h12:               return K_XMSGOK;
      default:             return K_UNKNOWN;
    endcase
  endfunction

  function automatic logic is_xfer(input cmd_kind_e k);
    return (k == K_XINFO) || (k == K_XCMPL) || (k == K_XMSGOK);
  endfunction

  function automatic cmpl_code_t cmpl_for(input cmd_kind_e k);
    cmpl_code_t c;
    c.status = ST_PEND | ST_TC | {5'b0, PH_STATUS};
    case (k)
      K_XCMPL:  begin c.intr = IR_BSERV | IR_FDONE; c.seq = SEQ_CMDOK; end
      K_XMSGOK: begin c.intr = IR_DISC;             c.seq = 8'h00;     end
      default:  begin c.intr = IR_BSERV;            c.seq = 8'h00;     end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/scsi_wr_bank.sv
module scsi_wr_bank
  import scsi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       cnt_lo,
  output logic [7:0]       cnt_hi
);
  logic [7:0] wq [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_wreg
    always_ff @(posedge clk) begin
      if (!rst_n)                                         wq[g] <= 8'h00;
      else if (wr_en && (wr_idx == IDX_W'(g)))            wq[g] <= wr_data;
    end
  end

  assign cnt_lo = wq[IDX_CNT_LO];
  assign cnt_hi = wq[IDX_CNT_HI];
endmodule

// File: rtl/scsi_cmd_fsm.sv
module scsi_cmd_fsm
  import scsi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [6:0]  cmd_op,
  input  logic [7:0]  cnt_lo,
  input  logic [7:0]  cnt_hi,
  input  logic        xfer_done,
  output logic        busy,
  output logic [15:0] xfer_len,
  output logic        flush_evt,
  output logic        chiprst_evt,
  output logic        noeff_evt,
  output logic        cmpl_evt,
  output cmpl_code_t  cmpl_code
);
  logic        busy_q;
  logic [15:0] len_q;
  cmd_kind_e   pend_q;
  cmd_kind_e   kind_now;
  logic        accept;
  logic        start_evt;

  assign kind_now    = classify(cmd_op);
  assign accept      = cmd_wr && !busy_q;
  assign flush_evt   = accept && (kind_now == K_FLUSH);
  assign chiprst_evt = accept && (kind_now == K_CHIPRST);
  assign noeff_evt   = accept && ((kind_now == K_NONE) || (kind_now == K_UNKNOWN));
  assign start_evt   = accept && is_xfer(kind_now);
  assign cmpl_evt    = busy_q && xfer_done;
  assign cmpl_code   = cmpl_for(pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      len_q  <= 16'h0;
      pend_q <= K_NONE;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      pend_q <= kind_now;
      len_q  <= (kind_now == K_XINFO) ? count16(cnt_lo, cnt_hi) : MSG_BYTES;
    end else if (cmpl_evt) begin
      busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign xfer_len = len_q;

  // R13: pending transfer is not disturbed by further commands
  a_r13_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_done) |=> busy_q);
  a_r13_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_done) |=> $stable(len_q));
  // R10: done ends the pending transfer
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> !busy_q);
endmodule

// File: rtl/scsi_rd_bank.sv
module scsi_rd_bank
  import scsi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             flush_evt,
  input  logic             chiprst_evt,
  input  logic             noeff_evt,
  input  logic             cmpl_evt,
  input  cmpl_code_t       cmpl_code,
  output logic [7:0]       rd_data
);
  logic [7:0] rq [N_REGS];

  function automatic logic [7:0] init_val(input int i);
    return (i == IDX_REV) ? REV_ID : 8'h00;
  endfunction

  for (genvar g = 0; g < N_REGS; g++) begin : g_rreg
    always_ff @(posedge clk) begin
      if (!rst_n || chiprst_evt) begin
        rq[g] <= init_val(g);
      end else if (flush_evt) begin
        if (g == IDX_INTR) rq[g] <= IR_FDONE;
        if (g == IDX_SEQ)  rq[g] <= 8'h00;
      end else if (cmpl_evt) begin
        if (g == IDX_STAT) rq[g] <= cmpl_code.status;
        if (g == IDX_INTR) rq[g] <= cmpl_code.intr;
        if (g == IDX_SEQ)  rq[g] <= cmpl_code.seq;
      end
    end
  end

  assign rd_data = rq[rd_idx];

  // R12: commands without effect keep the result registers
  a_r12_noeff_stable: assert property (@(posedge clk) disable iff (!rst_n)
    noeff_evt |=> ($stable(rq[IDX_STAT]) && $stable(rq[IDX_INTR]) && $stable(rq[IDX_SEQ])));
  // R5: flush leaves status alone
  a_r5_flush_status: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> ($stable(rq[IDX_STAT]) && rq[IDX_INTR] == IR_FDONE));
  // R6: revision id reloaded
  a_r6_rev_id: assert property (@(posedge clk) disable iff (!rst_n)
    chiprst_evt |=> (rq[IDX_REV] == REV_ID && rq[IDX_STAT] == 8'h00));
  // R10: completion marks interrupt pending in status
  a_r10_status_pend: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> rq[IDX_STAT][7]);
endmodule

// File: rtl/scsi_dma_ctrl.sv
module scsi_dma_ctrl
  import scsi_cmd_pkg::*;
#(
  parameter int DMA_W    = 32,
  parameter int DMA_REGS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_wr,
  input  logic [3:0]       dma_addr,
  input  logic [DMA_W-1:0] dma_wdata,
  input  logic             chiprst_evt,
  input  logic             cmpl_evt,
  output logic [DMA_W-1:0] dma_rdata,
  output logic             irq
);
  localparam int DIX_W = $clog2(DMA_REGS);
  localparam int EN_BIT = 4;

  logic [DMA_W-1:0] dq [DMA_REGS];
  logic [DIX_W-1:0] didx;
  logic             irq_q;
  logic             irq_clr;

  assign didx    = dma_addr[2 +: DIX_W];
  assign irq_clr = dma_wr && (didx == '0) && !dma_wdata[EN_BIT];

  for (genvar g = 0; g < DMA_REGS; g++) begin : g_dreg
    always_ff @(posedge clk) begin
      if (!rst_n || chiprst_evt) begin
        dq[g] <= '0;
      end else begin
        if (dma_wr && (didx == DIX_W'(g))) dq[g] <= dma_wdata;
        if (g == 0 && cmpl_evt) dq[g][0] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (cmpl_evt) irq_q <= 1'b1;
    else if (irq_clr)  irq_q <= 1'b0;
  end

  assign dma_rdata = dq[didx];
  assign irq       = irq_q;

  // R10: irq only rises after a completion
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cmpl_evt));
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> (dq[0][0] && irq_q));
  // R11: irq drops only on an enable-clear write
  a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(irq_clr));
  // R6: chip reset empties the DMA registers
  a_r6_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    chiprst_evt |=> (dq[DMA_REGS-1] == '0));
endmodule

// File: rtl/scsi_cmd_regfile.sv
module scsi_cmd_regfile
  import scsi_cmd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DMA_W    = 32,
  parameter int DMA_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dma_wr,
  input  logic [3:0]        dma_addr,
  input  logic [DMA_W-1:0]  dma_wdata,
  output logic [DMA_W-1:0]  dma_rdata,
  output logic              xfer_req,
  output logic [15:0]       xfer_len,
  input  logic              xfer_done,
  output logic              busy,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic [7:0]       cnt_lo, cnt_hi;
  logic             cmd_wr;
  logic             flush_evt, chiprst_evt, noeff_evt, cmpl_evt;
  cmpl_code_t       cmpl_code;

  assign idx    = reg_index(bus_addr[5:0]);
  assign cmd_wr = bus_wr && (idx == IDX_W'(IDX_CMD));

  scsi_wr_bank u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  scsi_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(bus_wdata[6:0]),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .xfer_done(xfer_done),
    .busy(busy), .xfer_len(xfer_len), .flush_evt(flush_evt),
    .chiprst_evt(chiprst_evt), .noeff_evt(noeff_evt),
    .cmpl_evt(cmpl_evt), .cmpl_code(cmpl_code)
  );

  scsi_rd_bank u_rd (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .flush_evt(flush_evt),
    .chiprst_evt(chiprst_evt), .noeff_evt(noeff_evt), .cmpl_evt(cmpl_evt),
    .cmpl_code(cmpl_code), .rd_data(bus_rdata)
  );

  scsi_dma_ctrl #(.DMA_W(DMA_W), .DMA_REGS(DMA_REGS)) u_dma (
    .clk(clk), .rst_n(rst_n), .dma_wr(dma_wr), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .chiprst_evt(chiprst_evt), .cmpl_evt(cmpl_evt),
    .dma_rdata(dma_rdata), .irq(irq)
  );

  assign xfer_req = busy;

  // R7: a request is only raised by a transfer-type command write
  a_r7_req_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(cmd_wr));
endmodule

// File: tb/scsi_cmd_regfile_bench.sv
module scsi_cmd_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        dma_wr;
  logic [3:0]  dma_addr;
  logic [31:0] dma_wdata;
  logic [31:0] dma_rdata;
  logic        xfer_req;
  logic [15:0] xfer_len;
  logic        xfer_done;
  logic        busy;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_cmd_regfile u_scsi_cmd_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_wr(dma_wr),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
    .xfer_req(xfer_req), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .busy(busy), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        xfer;
    logic [15:0] len;
    logic [7:0]  st;
    logic [7:0]  ir;
    logic [7:0]  sq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 8'h34, 8'h12, 1'b1, 16'h1234, 8'h93, 8'h10, 8'h00},
    '{8'h10, 8'hFF, 8'hFF, 1'b1, 16'hFFFF, 8'h93, 8'h10, 8'h00},
    '{8'h11, 8'h77, 8'h66, 1'b1, 16'h0002, 8'h93, 8'h18, 8'h04},
    '{8'h12, 8'h00, 8'h00, 1'b1, 16'h0002, 8'h93, 8'h20, 8'h00},
    '{8'h90, 8'h05, 8'h00, 1'b1, 16'h0005, 8'h93, 8'h10, 8'h00},
    '{8'h81, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h08, 8'h00},
    '{8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic dwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    dma_wr = 1'b1; dma_addr = a; dma_wdata = d;
    @(posedge clk);
    @(negedge clk);
    dma_wr = 1'b0;
  endtask

  task automatic dread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    dma_addr = a;
    #1 d = dma_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] dr;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    dma_wr = 1'b0; dma_addr = '0; dma_wdata = '0; xfer_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2 reset state
    bread(8'h10, r); check("R2 status", r, 8'h00);
    bread(8'h14, r); check("R2 intr", r, 8'h00);
    bread(8'h38, r); check("R2 rev", r, 8'h04);
    check("R2 irq", irq, 0);
    check("R2 busy", busy, 0);
    dread(4'h0, dr); check("R2 dma0", dr, 0);

    // vector table: R4 R5 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      bwrite(8'h0C, 8'h02);
      bwrite(8'h00, VECS[i].lo);
      bwrite(8'h04, VECS[i].hi);
      bwrite(8'h0C, VECS[i].op);
      check("R7/R8/R9 req", xfer_req, VECS[i].xfer);
      if (VECS[i].xfer) begin
        check("R7/R8/R9 len", xfer_len, VECS[i].len);
        pulse_done();
        check("R10 irq", irq, 1);
        check("R10 busy", busy, 0);
        dread(4'h0, dr); check("R10 dma0 bit0", dr[0], 1);
      end else begin
        check("R5/R12 irq", irq, 0);
      end
      bread(8'h10, r); check("R7/R8/R9/R4 status", r, VECS[i].st);
      bread(8'h14, r); check("R7/R8/R9/R5 intr", r, VECS[i].ir);
      bread(8'h18, r); check("R7/R8/R9 seq", r, VECS[i].sq);
      dwrite(4'h0, 32'h0);
      check("R11 irq cleared", irq, 0);
    end

    // R3: write bank does not show in reads
    bwrite(8'h0C, 8'h02);
    bwrite(8'h14, 8'hAA);
    bread(8'h14, r); check("R3 read bank", r, 8'h00);

    // R1: aliased address reaches command register
    bwrite(8'h4C, 8'h01);
    bread(8'h54, r); check("R1 alias intr", r, 8'h08);

    // R13: command during busy is dropped
    bwrite(8'h0C, 8'h11);
    bwrite(8'h00, 8'h09);
    bwrite(8'h0C, 8'h01);
    bwrite(8'h0C, 8'h10);
    check("R13 busy", busy, 1);
    check("R13 len", xfer_len, 16'h0002);
    bread(8'h14, r); check("R13 intr", r, 8'h08);
    pulse_done();
    bread(8'h14, r); check("R13 final intr", r, 8'h18);
    bread(8'h18, r); check("R13 final seq", r, 8'h04);

    // R11: enable bit set keeps irq
    dwrite(4'h0, 32'h10);
    check("R11 irq kept", irq, 1);

    // R12: no-effect commands on non-zero state
    bwrite(8'h0C, 8'h55);
    bwrite(8'h0C, 8'h1A);
    bwrite(8'h0C, 8'h03);
    bread(8'h10, r); check("R12 status", r, 8'h93);
    bread(8'h14, r); check("R12 intr", r, 8'h18);
    bread(8'h18, r); check("R12 seq", r, 8'h04);
    check("R12 irq", irq, 1);

    // R5: flush keeps status
    bwrite(8'h0C, 8'h01);
    bread(8'h10, r); check("R5 status", r, 8'h93);
    bread(8'h14, r); check("R5 intr", r, 8'h08);
    bread(8'h18, r); check("R5 seq", r, 8'h00);

    // R11: clear
    dwrite(4'h0, 32'h0);
    check("R11 irq drop", irq, 0);

    // R6: chip reset clears DMA and read registers
    dwrite(4'h8, 32'hDEADBEEF);
    dread(4'h8, dr); check("R6 dma2 written", dr, 32'hDEADBEEF);
    bwrite(8'h0C, 8'h02);
    dread(4'h8, dr); check("R6 dma2 cleared", dr, 32'h0);
    bread(8'h10, r); check("R6 status", r, 8'h00);
    bread(8'h38, r); check("R6 rev", r, 8'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule